// File: doc/BRIEF.md
# NTSC Raster Sync and Vertical Interrupt Generator

This block counts dot positions along a scan line and scan lines down a 262-line progressive frame, and turns those two counts into the timing strobes a video output stage needs: an active-low horizontal sync, an active-low composite sync, an active-low blanking indicator, a border flag, an active-picture flag and a one-dot vertical interrupt strobe. It advances only on cycles where the dot enable is high, so it can run from a fast system clock while a separate divider sets the dot rate.

A line starts at the falling edge of horizontal sync (dot 0). It then runs through six intervals: the 64-dot sync pulse, a 64-dot gap that is still blanked, a 26-dot left border, the active area (320 dots by default), a 28-dot right border and an 18-dot blanked gap before the next sync. With the defaults the line is 520 dots long. Lines are numbered from 1 to 262. Lines 31 to 254 carry picture. Lines 4 to 12 form the vertical sync region, where composite sync uses two half-width pulses per line. The vertical interrupt fires 40 dots after sync release on the first line after the picture.

Top module: `raster_sync_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the dot counter is 0 and the line counter is 1.
- R2: The dot and line counters change only on cycles where `dot_en` is high. With `dot_en` low they hold their values, and so do all decoded outputs.
- R3: The dot counter counts 0 to LINE_LEN-1 and then returns to 0, where LINE_LEN = HSYNC_W+POST_GAP+BORDER_L+ACTIVE_W+BORDER_R+PRE_GAP. The line counter increments when the dot counter wraps, and it goes from TOTAL_LINES back to 1.
- R4: `hsync_n` is 0 for dots 0 to HSYNC_W-1 on every line and 1 for all other dots.
- R5: `blank_n` is 0 for dots below HSYNC_W+POST_GAP and for dots at or above LINE_LEN-PRE_GAP, and 1 for all other dots.
- R6: `active` is 1 only when the line is in FIRST_ACTIVE to FIRST_ACTIVE+ACTIVE_LINES-1 and the dot is in HSYNC_W+POST_GAP+BORDER_L to that value plus ACTIVE_W-1.
- R7: `border` is 1 exactly when `blank_n` is 1 and `active` is 0. On non-picture lines the whole unblanked span is border.
- R8: Outside lines VS_FIRST to VS_FIRST+VS_LINES-1, `csync_n` equals `hsync_n`.
- R9: Inside that line region, `csync_n` is 0 for dots 0 to HSYNC_W/2-1 and for dots LINE_LEN/2 to LINE_LEN/2+HSYNC_W/2-1, and 1 for all other dots.
- R10: `vint` is 1 only at line FIRST_ACTIVE+ACTIVE_LINES, dot HSYNC_W+VINT_DELAY. That is a single enabled dot per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_en | input | 1 | Dot-rate advance enable |
| hsync_n | output | 1 | Horizontal sync, active low |
| csync_n | output | 1 | Composite sync, active low |
| blank_n | output | 1 | Low during horizontal blanking |
| border | output | 1 | Unblanked but not picture |
| active | output | 1 | Picture area |
| dot_cnt | output | DOT_W | Dot position, 0 at sync assert |
| line_cnt | output | LINE_W | Line number, 1 to TOTAL_LINES |
| vint | output | 1 | Vertical interrupt strobe |

## Verification
The bench uses a reduced configuration with a short line and frame. Over two full frames it compares every output at every dot against its own arithmetic model, and it removes the enable on scattered cycles. The first frame shows off-by-one edges at the sync release, blanking ends, border and active boundaries, and at the last dot and last line. A design that got these wrong would shift or widen one interval, or skip or repeat a line. The second frame tests the enable gaps: a counter that ignored `dot_en` would drift from the model, and an interrupt not tied to one dot would show up twice or not at all. The half-pulse lines are compared at the mid-line dot, where a design with the wrong mid-point or pulse width would put the second pulse in the wrong place.

// File: rtl/raster_pkg.sv
package raster_pkg;

  function automatic int unsigned calc_line_len(
    input int unsigned hs, input int unsigned pg, input int unsigned bl,
    input int unsigned aw, input int unsigned br, input int unsigned pre);
    return hs + pg + bl + aw + br + pre;
  endfunction

  // true when x lies in [lo, lo+len)
  function automatic logic in_span(input int unsigned x, input int unsigned lo,
                                   input int unsigned len);
    return (x >= lo) && (x < lo + len);
  endfunction

  typedef struct packed {
    logic hsync_n;
    logic csync_n;
    logic blank_n;
    logic border;
    logic active;
    logic vint;
  } raster_strobes_t;

endpackage

// File: rtl/raster_hcount.sv
module raster_hcount #(
  parameter int unsigned LINE_LEN = 520,
  localparam int unsigned DOT_W = $clog2(LINE_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dot_en,
  output logic [DOT_W-1:0] dot,
  output logic             line_wrap
);
  localparam logic [DOT_W-1:0] LAST_DOT = DOT_W'(LINE_LEN - 1);

  logic at_last;
  assign at_last   = (dot == LAST_DOT);
  assign line_wrap = dot_en && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dot <= '0;
    else if (dot_en)  dot <= at_last ? '0 : dot + 1'b1;
  end

  a_r3_dot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    line_wrap |=> (dot == '0));
  a_r3_dot_range: assert property (@(posedge clk) disable iff (!rst_n)
    dot <= LAST_DOT);
  a_r2_dot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_en |=> $stable(dot));
endmodule

// File: rtl/raster_vcount.sv
module raster_vcount #(
  parameter int unsigned TOTAL_LINES = 262,
  localparam int unsigned LINE_W = $clog2(TOTAL_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_wrap,
  output logic [LINE_W-1:0] line
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(TOTAL_LINES);
  localparam logic [LINE_W-1:0] FIRST_LINE = LINE_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          line <= FIRST_LINE;
    else if (line_wrap)  line <= (line == LAST_LINE) ? FIRST_LINE : line + 1'b1;
  end

  a_r3_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (line_wrap && line == LAST_LINE) |=> (line == FIRST_LINE));
  a_r3_line_range: assert property (@(posedge clk) disable iff (!rst_n)
    (line >= FIRST_LINE) && (line <= LAST_LINE));
  a_r2_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_wrap |=> $stable(line));
endmodule

// File: rtl/raster_decode.sv
module raster_decode
  import raster_pkg::*;
#(
  parameter int unsigned HSYNC_W      = 64,
  parameter int unsigned POST_GAP     = 64,
  parameter int unsigned BORDER_L     = 26,
  parameter int unsigned ACTIVE_W     = 320,
  parameter int unsigned BORDER_R     = 28,
  parameter int unsigned PRE_GAP      = 18,
  parameter int unsigned TOTAL_LINES  = 262,
  parameter int unsigned FIRST_ACTIVE = 31,
  parameter int unsigned ACTIVE_LINES = 224,
  parameter int unsigned VS_FIRST     = 4,
  parameter int unsigned VS_LINES     = 9,
  parameter int unsigned VINT_DELAY   = 40,
  localparam int unsigned LINE_LEN = calc_line_len(HSYNC_W, POST_GAP, BORDER_L,
                                                   ACTIVE_W, BORDER_R, PRE_GAP),
  localparam int unsigned DOT_W  = $clog2(LINE_LEN),
  localparam int unsigned LINE_W = $clog2(TOTAL_LINES + 1)
) (
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  output raster_strobes_t   strobes
);
  localparam int unsigned VIS_START = HSYNC_W + POST_GAP;
  localparam int unsigned VIS_LEN   = BORDER_L + ACTIVE_W + BORDER_R;
  localparam int unsigned ACT_START = VIS_START + BORDER_L;
  localparam int unsigned HALF_W    = HSYNC_W / 2;
  localparam int unsigned MID_DOT   = LINE_LEN / 2;
  localparam int unsigned VINT_LINE = FIRST_ACTIVE + ACTIVE_LINES;
  localparam int unsigned VINT_DOT  = HSYNC_W + VINT_DELAY;

  int unsigned d, l;
  assign d = 32'(dot);
  assign l = 32'(line);

  logic in_sync, in_vis, pic_line, pic_dot, vs_line, half_pulse;
  assign in_sync    = in_span(d, 0, HSYNC_W);
  assign in_vis     = in_span(d, VIS_START, VIS_LEN);
  assign pic_line   = in_span(l, FIRST_ACTIVE, ACTIVE_LINES);
  assign pic_dot    = in_span(d, ACT_START, ACTIVE_W);
  assign vs_line    = in_span(l, VS_FIRST, VS_LINES);
  assign half_pulse = in_span(d, 0, HALF_W) || in_span(d, MID_DOT, HALF_W);

  always_comb begin
    strobes.hsync_n = !in_sync;
    strobes.csync_n = vs_line ? !half_pulse : !in_sync;
    strobes.blank_n = in_vis;
    strobes.active  = pic_line && pic_dot;
    strobes.border  = in_vis && !(pic_line && pic_dot);
    strobes.vint    = (l == VINT_LINE) && (d == VINT_DOT);
  end

  a_r7_border_excl: assert property (@(strobes) !(strobes.border && strobes.active));
endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
  import raster_pkg::*;
#(
  parameter int unsigned HSYNC_W      = 64,
  parameter int unsigned POST_GAP     = 64,
  parameter int unsigned BORDER_L     = 26,
  parameter int unsigned ACTIVE_W     = 320,
  parameter int unsigned BORDER_R     = 28,
  parameter int unsigned PRE_GAP      = 18,
  parameter int unsigned TOTAL_LINES  = 262,
  parameter int unsigned FIRST_ACTIVE = 31,
  parameter int unsigned ACTIVE_LINES = 224,
  parameter int unsigned VS_FIRST     = 4,
  parameter int unsigned VS_LINES     = 9,
  parameter int unsigned VINT_DELAY   = 40,
  localparam int unsigned LINE_LEN = calc_line_len(HSYNC_W, POST_GAP, BORDER_L,
                                                   ACTIVE_W, BORDER_R, PRE_GAP),
  localparam int unsigned DOT_W  = $clog2(LINE_LEN),
  localparam int unsigned LINE_W = $clog2(TOTAL_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dot_en,
  output logic              hsync_n,
  output logic              csync_n,
  output logic              blank_n,
  output logic              border,
  output logic              active,
  output logic [DOT_W-1:0]  dot_cnt,
  output logic [LINE_W-1:0] line_cnt,
  output logic              vint
);
  logic            line_wrap;
  raster_strobes_t strobes;

  raster_hcount #(.LINE_LEN(LINE_LEN)) u_hcount (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .dot(dot_cnt), .line_wrap(line_wrap)
  );

  raster_vcount #(.TOTAL_LINES(TOTAL_LINES)) u_vcount (
    .clk(clk), .rst_n(rst_n), .line_wrap(line_wrap), .line(line_cnt)
  );

  raster_decode #(
    .HSYNC_W(HSYNC_W), .POST_GAP(POST_GAP), .BORDER_L(BORDER_L),
    .ACTIVE_W(ACTIVE_W), .BORDER_R(BORDER_R), .PRE_GAP(PRE_GAP),
    .TOTAL_LINES(TOTAL_LINES), .FIRST_ACTIVE(FIRST_ACTIVE),
    .ACTIVE_LINES(ACTIVE_LINES), .VS_FIRST(VS_FIRST), .VS_LINES(VS_LINES),
    .VINT_DELAY(VINT_DELAY)
  ) u_decode (
    .dot(dot_cnt), .line(line_cnt), .strobes(strobes)
  );

  assign hsync_n = strobes.hsync_n;
  assign csync_n = strobes.csync_n;
  assign blank_n = strobes.blank_n;
  assign border  = strobes.border;
  assign active  = strobes.active;
  assign vint    = strobes.vint;

  localparam logic [DOT_W-1:0] SYNC_END  = DOT_W'(HSYNC_W);
  localparam logic [DOT_W-1:0] BLANK_END = DOT_W'(HSYNC_W + POST_GAP);

  a_r4_hsync_fall_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_n) |-> (dot_cnt == '0));
  a_r4_hsync_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_n) |-> (dot_cnt == SYNC_END));
  a_r5_blank_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank_n) |-> (dot_cnt == BLANK_END));
  a_r10_vint_single: assert property (@(posedge clk) disable iff (!rst_n)
    (vint && dot_en) |=> !vint);
  a_r2_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_en |=> ($stable(hsync_n) && $stable(csync_n) && $stable(blank_n) && $stable(vint)));
endmodule

// File: tb/raster_sync_gen_tb.sv
module raster_sync_gen_tb;
  localparam int HS = 8, PG = 8, BL = 3, AW = 10, BR = 4, PRE = 2;
  localparam int TL = 20, FA = 5, AL = 8, VSF = 2, VSL = 3, VD = 5;
  localparam int LEN = HS + PG + BL + AW + BR + PRE;  // 35
  localparam int DW = $clog2(LEN);
  localparam int LW = $clog2(TL + 1);

  logic clk = 0, rst_n = 0, dot_en = 0;
  logic hsync_n, csync_n, blank_n, border, active, vint;
  logic [DW-1:0] dot_cnt;
  logic [LW-1:0] line_cnt;
  int n_chk = 0, n_fail = 0, vint_seen = 0;
  int ed = 0, el = 1;
  bit done = 0;

  always #10 clk = ~clk;

  raster_sync_gen #(
    .HSYNC_W(HS), .POST_GAP(PG), .BORDER_L(BL), .ACTIVE_W(AW), .BORDER_R(BR),
    .PRE_GAP(PRE), .TOTAL_LINES(TL), .FIRST_ACTIVE(FA), .ACTIVE_LINES(AL),
    .VS_FIRST(VSF), .VS_LINES(VSL), .VINT_DELAY(VD)
  ) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s line=%0d dot=%0d actual=%0d expected=%0d", req, el, ed, act, exp);
    end
  endtask

  task automatic check_all();
    bit blank, act_e, vs, half;
    blank = (ed < HS + PG) || (ed >= LEN - PRE);
    act_e = (el >= FA) && (el < FA + AL) && (ed >= HS + PG + BL) && (ed < HS + PG + BL + AW);
    vs    = (el >= VSF) && (el < VSF + VSL);
    half  = (ed < HS / 2) || ((ed >= LEN / 2) && (ed < LEN / 2 + HS / 2));
    chk("R3 dot", int'(dot_cnt), ed);
    chk("R3 line", int'(line_cnt), el);
    chk("R4 hsync_n", int'(hsync_n), int'(ed >= HS));
    chk("R5 blank_n", int'(blank_n), int'(!blank));
    chk("R6 active", int'(active), int'(act_e));
    chk("R7 border", int'(border), int'(!blank && !act_e));
    if (vs) chk("R9 csync_n half", int'(csync_n), int'(!half));
    else    chk("R8 csync_n", int'(csync_n), int'(ed >= HS));
    chk("R10 vint", int'(vint), int'(el == FA + AL && ed == HS + VD));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset dot", int'(dot_cnt), 0);
    chk("R1 reset line", int'(line_cnt), 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 post-reset dot", int'(dot_cnt), 0);
    chk("R1 post-reset line", int'(line_cnt), 1);
    // frame 1 continuous, frame 2 with enable gaps (R2)
    for (int i = 0; i < 2 * LEN * TL + 200; i++) begin
      bit en;
      check_all();
      if (vint) vint_seen++;
      en = (i < LEN * TL) ? 1'b1 : ((i % 7) != 3);
      if (!en) begin
        // R2: hold while disabled, checked after the edge
        dot_en = 0;
        @(negedge clk);
        chk("R2 hold dot", int'(dot_cnt), ed);
        chk("R2 hold line", int'(line_cnt), el);
      end
      dot_en = 1;
      if (ed == LEN - 1) begin
        ed = 0;
        el = (el == TL) ? 1 : el + 1;
      end else ed++;
      @(negedge clk);
    end
    dot_en = 0;
    // R10: exactly one strobe cycle per frame over two frames
    chk("R10 vint count", vint_seen, 2);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule